// File: doc/BRIEF.md
# Audio Converter Power-Up Sequencer

This block is the digital start-up controller of a stereo audio converter. It runs on the converter's master clock and watches the asynchronous frame (left/right) clock. It holds the interpolation and modulator datapath in reset until the frame clock is seen. It then measures how many master-clock cycles fit in one frame and maps the count onto one of five legal ratios. Only after that does it enable the voltage reference. After a settling interval counted in frames it enables the converter and filter stages. After a further interval in frames it releases mute.

A second, free-running reference clock supervises the master clock. If the master clock stops, the outputs fall back at once to their power-down values, and the sequence starts again from power-down when the clock returns. Loss of the frame clock, counted in master-clock cycles, also returns the block to power-down.

Alongside the sequencer, a level-sampled control pin selects de-emphasis. The pin is sampled on each falling frame edge, and a setting is accepted only after an unbroken run of equal samples. When the pin serves as an external bit clock, it has no effect on de-emphasis. The block has no data stream, so all of its pins are plain control and status levels with no handshake.

Top module: `aud_pwr_seq`

## Requirements
- R1: During and after reset the outputs show power-down: `dp_rst`=1, `ref_en`=0, `conv_en`=0, `mute`=1, `ratio_code`=7 (7 means no ratio known) and `deemph`=0.
- R2: The block stays in power-down until it sees a rising edge of `frame_clk`, taken through a two-flop synchronizer. That edge starts a ratio measurement.
- R3: The measured ratio is the number of master-clock cycles between two consecutive synchronized rising frame edges. It is accepted when it lies within ±RATIO_TOL (4) of a legal value. The codes are 0=256, 1=384, 2=512, 3=768 and 4=1024. The code is shown on `ratio_code` and stays unchanged while the datapath is out of reset.
- R4: A count outside every window is rejected. The enables stay off, `dp_rst` stays 1, and measurement restarts from the edge that ended the bad count.
- R5: On the rising edge that yields a legal ratio, `ref_en` goes to 1 and `dp_rst` goes to 0. `conv_en` goes to 1 only after SETTLE_FRAMES further rising frame edges.
- R6: `mute` goes to 0 after UNMUTE_FRAMES further rising frame edges once `conv_en` is 1. It is never 0 while `conv_en` is 0.
- R7: If no frame edge of either polarity is seen for LRCK_TIMEOUT master-clock cycles, the block returns to power-down from any state.
- R8: If the master clock stops for REF_TIMEOUT reference-clock cycles, all outputs except `deemph` take their power-down values without any master-clock edge. When the master clock resumes, the block is in power-down and needs a new measurement.
- R9: With `bitclk_ext`=0, `emph_pin` is sampled on each synchronized falling frame edge. DEEMPH_RUN (5) consecutive low samples set `deemph`=1, and DEEMPH_RUN consecutive high samples clear it. A sample that differs from the previous one restarts the run.
- R10: With `bitclk_ext`=1, `deemph` is 0 at once and `emph_pin` is ignored. Each falling frame edge in this mode clears the stored flag and the run. After the mode returns to 0, a fresh full run is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mst_clk | input | 1 | Master clock; all sequencing runs on it |
| ref_clk | input | 1 | Free-running supervision clock, slower than the master clock |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| frame_clk | input | 1 | Asynchronous frame (left/right) clock |
| emph_pin | input | 1 | De-emphasis select pin (low = on); acts as a bit clock when `bitclk_ext`=1 |
| bitclk_ext | input | 1 | 1 = external bit-clock mode; de-emphasis control disabled |
| dp_rst | output | 1 | Holds the interpolation and modulator datapath in reset |
| ref_en | output | 1 | Voltage reference enable |
| conv_en | output | 1 | Converter and switched-capacitor filter enable |
| mute | output | 1 | Audio mute |
| ratio_code | output | 3 | Measured master-to-frame ratio code (0..4, or 7 when unknown) |
| deemph | output | 1 | De-emphasis filter active |

## Verification
The hardest case to reach is the loss of the master clock. Every register that produces the sequencer's outputs runs on that clock, so nothing observable can change while it is stopped. The bench gates its own master clock low while the reference clock keeps running. It samples the outputs on reference-clock edges to see them forced to power-down. It then restarts the master clock with the frame clock held still, to confirm that the block sits in power-down until a new measurement. The ±4 window edges (252, 1028 and 1029 cycles) and a broken run on the de-emphasis pin are driven as exact frame periods and sample patterns.

// File: rtl/aud_pwr_seq_pkg.sv
package aud_pwr_seq_pkg;

  typedef enum logic [2:0] {
    SEQ_OFF     = 3'd0,
    SEQ_MEASURE = 3'd1,
    SEQ_REF     = 3'd2,
    SEQ_CONV    = 3'd3,
    SEQ_LIVE    = 3'd4
  } seq_state_t;

  localparam int NUM_RATIOS = 5;
  localparam logic [2:0] RATIO_NONE = 3'd7;

  // Legal master-clock cycles per frame, indexed by ratio code.
  function automatic int ratio_of(input int idx);
    case (idx)
      0:       return 256;
      1:       return 384;
      2:       return 512;
      3:       return 768;
      default: return 1024;
    endcase
  endfunction

endpackage

// File: rtl/aps_sync2.sv
module aps_sync2 #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/aps_frame_front.sv
// Frame-clock front end: synchronizer, edge pulses and quiet-line watchdog.
module aps_frame_front #(
  parameter int GAP_LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_async,
  input  logic pin_async,
  output logic frame_rise,
  output logic frame_fall,
  output logic pin_sync,
  output logic frame_quiet
);
  localparam int GAP_W = $clog2(GAP_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_LIMIT);

  logic fr_s;
  logic fr_prev;
  logic [GAP_W-1:0] gap;

  aps_sync2 #(.RST_VAL(1'b0)) u_fr_sync (
    .clk(clk), .rst_n(rst_n), .d(frame_async), .q(fr_s)
  );

  aps_sync2 #(.RST_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_async), .q(pin_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fr_prev <= 1'b0;
    else        fr_prev <= fr_s;
  end

  assign frame_rise = fr_s & ~fr_prev;
  assign frame_fall = ~fr_s & fr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
    end else if (frame_rise || frame_fall) begin
      gap <= '0;
    end else if (gap != GAP_MAX) begin
      gap <= gap + GAP_W'(1);
    end
  end

  assign frame_quiet = (gap == GAP_MAX);
endmodule

// File: rtl/aps_ratio_classify.sv
// Maps a cycle count onto the nearest legal ratio within a tolerance window.
module aps_ratio_classify #(
  parameter int CNT_W = 12,
  parameter int TOL   = 4
) (
  input  logic [CNT_W-1:0] count,
  output logic             hit_any,
  output logic [2:0]       code
);
  import aud_pwr_seq_pkg::*;

  logic [NUM_RATIOS-1:0] hit;

  for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_window
    localparam int CENTRE = ratio_of(g);
    assign hit[g] = (int'(count) >= CENTRE - TOL) && (int'(count) <= CENTRE + TOL);
  end

  always_comb begin
    code = RATIO_NONE;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) code = 3'(i);
    end
  end

  assign hit_any = |hit;
endmodule

// File: rtl/aps_emph_detect.sv
// De-emphasis run detector, sampled on falling frame edges.
module aps_emph_detect #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_fall,
  input  logic pin,
  input  logic ext_mode,
  output logic deemph
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] run;
  logic [RUN_W-1:0] run_nx;
  logic             last;
  logic             flag;

  always_comb begin
    if (pin != last)      run_nx = RUN_W'(1);
    else if (run != RUN_MAX) run_nx = run + RUN_W'(1);
    else                  run_nx = run;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= '0;
      last <= 1'b1;
      flag <= 1'b0;
    end else if (frame_fall) begin
      if (ext_mode) begin
        run  <= '0;
        flag <= 1'b0;
      end else begin
        run  <= run_nx;
        last <= pin;
        if (run_nx == RUN_MAX) flag <= ~pin;
      end
    end
  end

  assign deemph = flag & ~ext_mode;
endmodule

// File: rtl/aps_clk_watch.sv
// Master-clock supervision: heartbeat divided from the master clock is
// watched from the reference clock domain.
module aps_clk_watch #(
  parameter int HB_W      = 4,
  parameter int REF_LIMIT = 16
) (
  input  logic mst_clk,
  input  logic ref_clk,
  input  logic rst_n,
  output logic lost_ref,
  output logic lost_mst
);
  localparam int IDLE_W = $clog2(REF_LIMIT + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(REF_LIMIT);

  logic [HB_W-1:0]   hb_div;
  logic              hb_s;
  logic              hb_prev;
  logic [IDLE_W-1:0] idle;

  always_ff @(posedge mst_clk or negedge rst_n) begin
    if (!rst_n) hb_div <= '0;
    else        hb_div <= hb_div + HB_W'(1);
  end

  aps_sync2 #(.RST_VAL(1'b0)) u_hb_sync (
    .clk(ref_clk), .rst_n(rst_n), .d(hb_div[HB_W-1]), .q(hb_s)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      hb_prev <= 1'b0;
      idle    <= '0;
    end else begin
      hb_prev <= hb_s;
      if (hb_s != hb_prev)   idle <= '0;
      else if (idle != IDLE_MAX) idle <= idle + IDLE_W'(1);
    end
  end

  assign lost_ref = (idle == IDLE_MAX);

  aps_sync2 #(.RST_VAL(1'b0)) u_lost_sync (
    .clk(mst_clk), .rst_n(rst_n), .d(lost_ref), .q(lost_mst)
  );
endmodule

// File: rtl/aud_pwr_seq.sv
module aud_pwr_seq #(
  parameter int LRCK_TIMEOUT  = 2048,
  parameter int SETTLE_FRAMES = 1024,
  parameter int UNMUTE_FRAMES = 2000,
  parameter int RATIO_TOL     = 4,
  parameter int DEEMPH_RUN    = 5,
  parameter int HB_W          = 4,
  parameter int REF_TIMEOUT   = 16
) (
  input  logic       mst_clk,
  input  logic       ref_clk,
  input  logic       rst_n,
  input  logic       frame_clk,
  input  logic       emph_pin,
  input  logic       bitclk_ext,
  output logic       dp_rst,
  output logic       ref_en,
  output logic       conv_en,
  output logic       mute,
  output logic [2:0] ratio_code,
  output logic       deemph
);
  import aud_pwr_seq_pkg::*;

  localparam int CNT_W   = $clog2(LRCK_TIMEOUT + 2);
  localparam int FR_MAX  = (SETTLE_FRAMES > UNMUTE_FRAMES) ? SETTLE_FRAMES : UNMUTE_FRAMES;
  localparam int FRAME_W = $clog2(FR_MAX + 1);
  localparam logic [FRAME_W-1:0] SETTLE_LAST = FRAME_W'(SETTLE_FRAMES - 1);
  localparam logic [FRAME_W-1:0] UNMUTE_LAST = FRAME_W'(UNMUTE_FRAMES - 1);

  logic rise, fall, pin_s, quiet;
  logic lost_ref, lost_mst;
  logic ratio_ok;
  logic [2:0] ratio_cand;

  seq_state_t         state;
  logic [CNT_W-1:0]   meas_cnt;
  logic [FRAME_W-1:0] frames;
  logic [2:0]         code_q;

  aps_frame_front #(.GAP_LIMIT(LRCK_TIMEOUT)) u_front (
    .clk(mst_clk), .rst_n(rst_n), .frame_async(frame_clk), .pin_async(emph_pin),
    .frame_rise(rise), .frame_fall(fall), .pin_sync(pin_s), .frame_quiet(quiet)
  );

  aps_ratio_classify #(.CNT_W(CNT_W), .TOL(RATIO_TOL)) u_classify (
    .count(meas_cnt), .hit_any(ratio_ok), .code(ratio_cand)
  );

  aps_emph_detect #(.RUN_LEN(DEEMPH_RUN)) u_emph (
    .clk(mst_clk), .rst_n(rst_n), .frame_fall(fall), .pin(pin_s),
    .ext_mode(bitclk_ext), .deemph(deemph)
  );

  aps_clk_watch #(.HB_W(HB_W), .REF_LIMIT(REF_TIMEOUT)) u_watch (
    .mst_clk(mst_clk), .ref_clk(ref_clk), .rst_n(rst_n),
    .lost_ref(lost_ref), .lost_mst(lost_mst)
  );

  always_ff @(posedge mst_clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_OFF;
      meas_cnt <= '0;
      frames   <= '0;
      code_q   <= RATIO_NONE;
    end else if (lost_mst) begin
      state <= SEQ_OFF;
    end else begin
      case (state)
        SEQ_OFF: begin
          if (rise) begin
            state    <= SEQ_MEASURE;
            meas_cnt <= CNT_W'(1);
          end
        end
        SEQ_MEASURE: begin
          if (quiet) begin
            state <= SEQ_OFF;
          end else if (rise) begin
            if (ratio_ok) begin
              code_q <= ratio_cand;
              frames <= '0;
              state  <= SEQ_REF;
            end else begin
              meas_cnt <= CNT_W'(1);
            end
          end else begin
            meas_cnt <= meas_cnt + CNT_W'(1);
          end
        end
        SEQ_REF: begin
          if (quiet) begin
            state <= SEQ_OFF;
          end else if (rise) begin
            if (frames == SETTLE_LAST) begin
              frames <= '0;
              state  <= SEQ_CONV;
            end else begin
              frames <= frames + FRAME_W'(1);
            end
          end
        end
        SEQ_CONV: begin
          if (quiet) begin
            state <= SEQ_OFF;
          end else if (rise) begin
            if (frames == UNMUTE_LAST) begin
              frames <= '0;
              state  <= SEQ_LIVE;
            end else begin
              frames <= frames + FRAME_W'(1);
            end
          end
        end
        SEQ_LIVE: begin
          if (quiet) state <= SEQ_OFF;
        end
        default: state <= SEQ_OFF;
      endcase
    end
  end

  logic st_early;
  assign st_early = (state == SEQ_OFF) || (state == SEQ_MEASURE);

  always_comb begin
    dp_rst     = lost_ref | st_early;
    ref_en     = ~lost_ref & ~st_early;
    conv_en    = ~lost_ref & ((state == SEQ_CONV) || (state == SEQ_LIVE));
    mute       = lost_ref | (state != SEQ_LIVE);
    ratio_code = (lost_ref || st_early) ? RATIO_NONE : code_q;
  end
endmodule

// File: rtl/aud_pwr_seq_checker.sv
module aud_pwr_seq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bitclk_ext,
  input logic       dp_rst,
  input logic       ref_en,
  input logic       conv_en,
  input logic       mute,
  input logic [2:0] ratio_code,
  input logic       deemph
);
  // R1: power-down view is consistent across all outputs
  a_r1_off_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    dp_rst |-> (!ref_en && !conv_en && mute && ratio_code == 3'd7));

  // R3: a released datapath always carries a legal code
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_rst |-> (ratio_code <= 3'd4));

  // R3: code holds while running
  a_r3_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_rst && $past(!dp_rst)) |-> $stable(ratio_code));

  // R5: converter needs the reference
  a_r5_conv_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en |-> ref_en);

  // R5: reference comes on straight out of measurement, converter still off
  a_r5_ref_from_measure: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_en) |-> ($past(dp_rst) && !conv_en));

  // R6: unmuted only with converter on
  a_r6_unmute_needs_conv: assert property (@(posedge clk) disable iff (!rst_n)
    !mute |-> conv_en);

  // R6: mute release follows an enabled converter
  a_r6_mute_order: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute) |-> $past(conv_en));

  // R10: external bit-clock mode keeps de-emphasis off
  a_r10_ext_off: assert property (@(posedge clk) disable iff (!rst_n)
    bitclk_ext |-> !deemph);
endmodule

bind aud_pwr_seq aud_pwr_seq_checker u_aud_pwr_seq_checker (
  .clk(mst_clk), .rst_n(rst_n), .bitclk_ext(bitclk_ext), .dp_rst(dp_rst),
  .ref_en(ref_en), .conv_en(conv_en), .mute(mute), .ratio_code(ratio_code),
  .deemph(deemph)
);

// File: tb/aud_pwr_seq_bench.sv
module aud_pwr_seq_bench;
  localparam int TIMEOUT = 2048;
  localparam int SETTLE  = 4;
  localparam int UNMUTE  = 6;
  localparam int TOL     = 4;
  localparam int RUNLEN  = 5;

  logic mst_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_clk = 1'b0;
  logic emph_pin = 1'b1;
  logic bitclk_ext = 1'b0;
  logic dp_rst, ref_en, conv_en, mute, deemph;
  logic [2:0] ratio_code;

  bit clk_en = 1'b1;
  bit cmp_en = 1'b0;
  int lr_period = 0;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  aud_pwr_seq #(
    .LRCK_TIMEOUT(TIMEOUT), .SETTLE_FRAMES(SETTLE), .UNMUTE_FRAMES(UNMUTE),
    .RATIO_TOL(TOL), .DEEMPH_RUN(RUNLEN), .HB_W(4), .REF_TIMEOUT(16)
  ) u_aud_pwr_seq (
    .mst_clk(mst_clk), .ref_clk(ref_clk), .rst_n(rst_n), .frame_clk(frame_clk),
    .emph_pin(emph_pin), .bitclk_ext(bitclk_ext), .dp_rst(dp_rst), .ref_en(ref_en),
    .conv_en(conv_en), .mute(mute), .ratio_code(ratio_code), .deemph(deemph)
  );

  // 100 MHz master clock that can be stopped low; 25 MHz supervision clock
  initial forever begin
    #5;
    if (clk_en) mst_clk = ~mst_clk;
  end
  initial forever #20 ref_clk = ~ref_clk;

  // Frame clock generator: high for the first half of each period
  initial begin
    int cur = 0;
    int phase = 0;
    forever begin
      @(negedge mst_clk);
      if (lr_period != cur) begin
        cur = lr_period;
        phase = 0;
      end else if (cur != 0) begin
        phase = (phase + 1) % cur;
      end
      if (cur != 0) frame_clk = (phase < cur / 2);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  legal[5] = '{256, 384, 512, 768, 1024};
  int  m_st, m_cnt, m_frames, m_code, m_gap, m_run;
  bit  m_hist[$];
  bit  m_pin_hist[$];
  bit  m_prev, m_last, m_flag, m_force;

  function automatic int classify(input int n);
    for (int i = 0; i < 5; i++)
      if (n - legal[i] <= TOL && legal[i] - n <= TOL) return i;
    return -1;
  endfunction

  always @(posedge mst_clk or negedge rst_n) begin : model
    bit s, rise, fall, quiet, v;
    int c;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_frames = 0; m_code = 7; m_gap = 0; m_run = 0;
      m_hist = '{1'b0, 1'b0}; m_pin_hist = '{1'b1, 1'b1};
      m_prev = 0; m_last = 1; m_flag = 0;
    end else begin
      s = m_hist[1];
      rise = s && !m_prev;
      fall = !s && m_prev;
      quiet = (m_gap == TIMEOUT);
      if (m_force) begin
        m_st = 0; m_force = 0;
      end else begin
        case (m_st)
          0: if (rise) begin m_st = 1; m_cnt = 1; end
          1: if (quiet) m_st = 0;
             else if (rise) begin
               c = classify(m_cnt);
               if (c >= 0) begin m_code = c; m_frames = 0; m_st = 2; end
               else m_cnt = 1;
             end else m_cnt++;
          2: if (quiet) m_st = 0;
             else if (rise) begin
               if (m_frames == SETTLE - 1) begin m_frames = 0; m_st = 3; end
               else m_frames++;
             end
          3: if (quiet) m_st = 0;
             else if (rise) begin
               if (m_frames == UNMUTE - 1) begin m_frames = 0; m_st = 4; end
               else m_frames++;
             end
          default: if (quiet) m_st = 0;
        endcase
      end
      if (rise || fall) m_gap = 0;
      else if (m_gap < TIMEOUT) m_gap++;
      if (fall) begin
        if (bitclk_ext) begin
          m_run = 0; m_flag = 0;
        end else begin
          v = m_pin_hist[1];
          if (v == m_last) begin if (m_run < RUNLEN) m_run++; end
          else begin m_run = 1; m_last = v; end
          if (m_run == RUNLEN) m_flag = !v;
        end
      end
      m_prev = s;
      m_hist.push_front(frame_clk);  void'(m_hist.pop_back());
      m_pin_hist.push_front(emph_pin); void'(m_pin_hist.pop_back());
    end
  end

  always @(negedge mst_clk) begin
    if (rst_n && cmp_en && !done) begin
      chk("R2/R5 dp_rst", int'(dp_rst), int'(m_st <= 1));
      chk("R5 ref_en", int'(ref_en), int'(m_st >= 2));
      chk("R5 conv_en", int'(conv_en), int'(m_st >= 3));
      chk("R6 mute", int'(mute), int'(m_st != 4));
      chk("R3 ratio_code", int'(ratio_code), (m_st <= 1) ? 7 : m_code);
      chk("R9 deemph", int'(deemph), int'(m_flag && !bitclk_ext));
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    repeat (n) @(negedge mst_clk);
  endtask

  task automatic after_edge;
    @(posedge mst_clk);
    #1;
  endtask

  task automatic set_period(input int p);
    after_edge();
    lr_period = p;
  endtask

  task automatic set_pin(input bit v);
    after_edge();
    emph_pin = v;
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  int periods[7] = '{384, 512, 768, 1024, 1028, 260, 252};
  int codes[7]   = '{1, 2, 3, 4, 4, 0, 0};

  initial begin
    repeat (5) @(posedge mst_clk);
    #1 rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge mst_clk);
    // R1 reset state
    chk("R1 dp_rst", int'(dp_rst), 1);
    chk("R1 ref_en", int'(ref_en), 0);
    chk("R1 mute", int'(mute), 1);
    chk("R1 ratio_code", int'(ratio_code), 7);
    chk("R1 deemph", int'(deemph), 0);

    // R2: no frame clock -> stays down
    cyc(300);
    chk("R2 idle dp_rst", int'(dp_rst), 1);
    chk("R2 idle ref_en", int'(ref_en), 0);

    // R5/R6: full sequence at 256
    set_period(256);
    cyc(256 * 3);
    chk("R5 ref on", int'(ref_en), 1);
    chk("R5 conv not yet", int'(conv_en), 0);
    cyc(256 * 10);
    chk("R6 unmuted", int'(mute), 0);
    chk("R3 code 256", int'(ratio_code), 0);

    // R9: de-emphasis runs
    set_pin(1'b0);
    cyc(256 * 7);
    chk("R9 on after low run", int'(deemph), 1);
    set_pin(1'b1); cyc(256 * 3);
    set_pin(1'b0); cyc(256);
    set_pin(1'b1); cyc(256 * 3);
    chk("R9 broken high run keeps on", int'(deemph), 1);
    cyc(256 * 3);
    chk("R9 off after high run", int'(deemph), 0);

    // R10: external bit-clock mode
    after_edge(); bitclk_ext = 1'b1; emph_pin = 1'b0;
    cyc(256 * 7);
    chk("R10 pin ignored", int'(deemph), 0);
    after_edge(); bitclk_ext = 1'b0;
    cyc(256 * 3);
    chk("R10 fresh run needed", int'(deemph), 0);
    cyc(256 * 4);
    chk("R10 on after fresh run", int'(deemph), 1);
    after_edge(); bitclk_ext = 1'b1;
    @(negedge mst_clk);
    chk("R10 immediate off", int'(deemph), 0);
    cyc(256 * 2);
    after_edge(); bitclk_ext = 1'b0; emph_pin = 1'b1;

    // R7: frame clock loss from live state
    set_period(0);
    cyc(2100);
    chk("R7 down after loss", int'(dp_rst), 1);
    chk("R7 muted", int'(mute), 1);

    // R3: each legal ratio and the window edges
    for (int i = 0; i < 7; i++) begin
      set_period(periods[i]);
      cyc(periods[i] * 4);
      chk("R3 ratio code", int'(ratio_code), codes[i]);
      chk("R3 ref on", int'(ref_en), 1);
      set_period(0);
      cyc(2100);
      chk("R7 back down", int'(dp_rst), 1);
    end

    // R4: out-of-window period then recovery
    set_period(1029);
    cyc(1029 * 5);
    chk("R4 rejected ref_en", int'(ref_en), 0);
    chk("R4 rejected dp_rst", int'(dp_rst), 1);
    set_period(256);
    cyc(256 * 5);
    chk("R4 re-measured ref_en", int'(ref_en), 1);
    chk("R4 re-measured code", int'(ratio_code), 0);
    cyc(256 * 10);
    chk("R6 live again", int'(mute), 0);

    // R8: master clock stop
    set_period(0);
    cyc(10);
    @(negedge mst_clk);
    clk_en = 1'b0;
    repeat (60) @(negedge ref_clk);
    chk("R8 forced mute", int'(mute), 1);
    chk("R8 forced ref_en", int'(ref_en), 0);
    chk("R8 forced conv_en", int'(conv_en), 0);
    chk("R8 forced dp_rst", int'(dp_rst), 1);
    chk("R8 forced code", int'(ratio_code), 7);
    m_force = 1'b1;
    @(negedge ref_clk);
    clk_en = 1'b1;
    cyc(100);
    chk("R8 resumed down", int'(dp_rst), 1);
    chk("R8 resumed ref_en", int'(ref_en), 0);
    set_period(512);
    cyc(512 * 13);
    chk("R8 new sequence unmuted", int'(mute), 0);
    chk("R8 new code", int'(ratio_code), 2);

    finish_run();
  end
endmodule